// File: doc/BRIEF.md
# Segmented Word Access Counter with Address Stepping

This block tracks which 16-bit slice of a 64-bit memory word a data bus cycle touches, and moves the word address after a word access is complete. A configuration write sets a first slice and a last slice, each from 0 to 3. A slice counter starts at the first slice and advances by one, modulo four, on every data cycle. When a data cycle lands on the last slice, the counter returns to the first slice. The controller can therefore move a whole word, or only part of one, as a burst of narrow bus cycles.

Two copies of the word address are kept, a foreground one and a background one. A select input picks one copy, and only that copy is read, loaded or stepped. A two-bit mode field sets the stepping direction: up, down, or none. The address steps once when the last-slice data cycle occurs while the persistent access target is the array at the address register. It also steps when an instruction runs that accesses the array at the register address or at an immediate address. Array storage and bus decoding sit outside this block.

Top module: `seg_addr_stepper`

## Requirements
- R1: After reset, `seg_idx` is 0, the first slice is 0, the last slice is 3, both address copies are 0 and `word_done` is 0.
- R2: When `seg_cfg_we` is 1, the first and last slice limits are loaded from `seg_cfg_start` and `seg_cfg_end`. On the next cycle `seg_idx` equals the new first slice. This write takes priority over a data cycle in the same clock, and that data cycle neither completes a word nor steps the address.
- R3: A data cycle (`data_cycle`=1) whose `seg_idx` differs from the last slice moves `seg_idx` to `seg_idx`+1 modulo 4, so slice 3 is followed by slice 0.
- R4: A data cycle whose `seg_idx` equals the last slice reloads `seg_idx` to the first slice and sets `word_done` to 1 for the following cycle only. When the first and last slices are equal, every data cycle completes a word.
- R5: In a cycle with no data cycle and no configuration write, `seg_idx` keeps its value and `word_done` is 0 in the following cycle.
- R6: The mode field `step_mode` is decoded as 2'b01 for increment, 2'b10 for decrement, and 2'b00 or 2'b11 for no change. The address wraps modulo 2^AW, so with AW=8 the value 255 is followed by 0 and 0 is followed by 255.
- R7: A last-slice data cycle steps the selected address only when `persist_is_ar` is 1. When `persist_is_ar` is 0, the address is left unchanged.
- R8: `instr_exec`=1 steps the selected address by one step in the current mode. If it coincides with a last-slice stepping data cycle, the address still steps only once.
- R9: `bank_sel` (0 for foreground, 1 for background) chooses which copy `addr_q` shows and which copy is loaded or stepped. The copy that is not selected keeps its value.
- R10: `addr_we`=1 loads `addr_wdata` into the selected copy and takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_cfg_we | input | 1 | Load the slice limits |
| seg_cfg_start | input | SEGW (2) | First slice of a word access |
| seg_cfg_end | input | SEGW (2) | Last slice of a word access |
| data_cycle | input | 1 | One 16-bit data bus cycle this clock |
| persist_is_ar | input | 1 | Persistent target is the array at the address register |
| instr_exec | input | 1 | Instruction accessing the array at the register or an immediate address runs |
| step_mode | input | 2 | 01 increment, 10 decrement, 00/11 no change |
| bank_sel | input | BSW (1) | 0 foreground copy, 1 background copy |
| addr_we | input | 1 | Load the selected address copy |
| addr_wdata | input | AW (8) | Value for an address load |
| seg_idx | output | SEGW (2) | Slice the next data cycle touches |
| seg_last | output | 1 | `seg_idx` equals the last slice |
| word_done | output | 1 | The previous clock completed the last slice |
| addr_q | output | AW (8) | Selected address copy |

## Verification
The assertions assume that `bank_sel` always names an existing copy and that every input has a known value from the first clock after reset. They also assume that `bank_sel` stays constant from the driving edge to the sampling point, because the checks on the copy that is not selected compare each register against the select value of the previous cycle. The stimulus changes inputs only on the falling clock edge and uses only 0 and 1 for `bank_sel`. It exercises every mode encoding, equal first and last slices, and a first slice above the last one, so the counter wraps through slice 0.

// File: rtl/segstep_pkg.sv
package segstep_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD     = 2'b00,
    STEP_INC      = 2'b01,
    STEP_DEC      = 2'b10,
    STEP_HOLD_ALT = 2'b11
  } step_mode_e;
endpackage

// File: rtl/seg_counter.sv
module seg_counter #(
  parameter int SEGW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [SEGW-1:0] cfg_start,
  input  logic [SEGW-1:0] cfg_end,
  input  logic            data_cycle,
  output logic [SEGW-1:0] seg_q,
  output logic            at_end,
  output logic            done_q
);
  logic [SEGW-1:0] start_q;
  logic [SEGW-1:0] end_q;

  assign at_end = (seg_q == end_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '1;
      seg_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we) begin
        start_q <= cfg_start;
        end_q   <= cfg_end;
        seg_q   <= cfg_start;
      end else if (data_cycle) begin
        if (at_end) begin
          seg_q  <= start_q;
          done_q <= 1'b1;
        end else begin
          seg_q <= seg_q + 1'b1;
        end
      end
    end
  end

  // R2: a configuration write reloads the slice counter
  p_cfg_reload_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> seg_q == $past(cfg_start));
  // R3: a data cycle below the last slice advances by one
  p_seg_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && data_cycle && !at_end) |=> seg_q == $past(seg_q) + 1'b1);
  // R4: completing the last slice pulses done for one cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && data_cycle && at_end) |=> done_q);
  // R5: no traffic, no motion
  p_seg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !data_cycle) |=> ($stable(seg_q) && !done_q));
endmodule

// File: rtl/addr_next.sv
module addr_next
  import segstep_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] cur,
  input  step_mode_e    mode,
  output logic [AW-1:0] nxt
);
  always_comb begin
    unique case (mode)
      STEP_INC: nxt = cur + 1'b1;
      STEP_DEC: nxt = cur - 1'b1;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/addr_stepper.sv
module addr_stepper
  import segstep_pkg::*;
#(
  parameter int AW    = 8,
  parameter int NBANK = 2,
  localparam int BSW  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [BSW-1:0] bank_sel,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_data,
  input  logic           step_evt,
  input  step_mode_e     mode,
  output logic [AW-1:0]  addr_sel
);
  logic [AW-1:0] bank_q [NBANK];
  logic [AW-1:0] nxt;

  assign addr_sel = bank_q[bank_sel];

  addr_next #(.AW(AW)) u_next (
    .cur  (addr_sel),
    .mode (mode),
    .nxt  (nxt)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[b] <= '0;
      end else if (bank_sel == BSW'(b)) begin
        if (wr_en) begin
          bank_q[b] <= wr_data;
        end else if (step_evt) begin
          bank_q[b] <= nxt;
        end
      end
    end

    // R9: a copy that is not selected never moves
    p_unsel_stable_r9: assert property (@(posedge clk) disable iff (rst)
      (bank_sel != BSW'(b)) |=> $stable(bank_q[b]));
  end

  // R6: an increment step adds one modulo 2^AW
  p_inc_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (step_evt && !wr_en && mode == STEP_INC)
      |=> bank_q[$past(bank_sel)] == AW'($past(addr_sel) + 1'b1));
  // R6: a decrement step subtracts one modulo 2^AW
  p_dec_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (step_evt && !wr_en && mode == STEP_DEC)
      |=> bank_q[$past(bank_sel)] == AW'($past(addr_sel) - 1'b1));
  // R7: without a step or a load the selected copy holds
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!step_evt && !wr_en) |=> bank_q[$past(bank_sel)] == $past(addr_sel));
  // R10: a load wins over a step
  p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> bank_q[$past(bank_sel)] == $past(wr_data));
endmodule

// File: rtl/seg_addr_stepper.sv
module seg_addr_stepper
  import segstep_pkg::*;
#(
  parameter int AW    = 8,
  parameter int SEGW  = 2,
  parameter int NBANK = 2,
  localparam int BSW  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            seg_cfg_we,
  input  logic [SEGW-1:0] seg_cfg_start,
  input  logic [SEGW-1:0] seg_cfg_end,
  input  logic            data_cycle,
  input  logic            persist_is_ar,
  input  logic            instr_exec,
  input  logic [1:0]      step_mode,
  input  logic [BSW-1:0]  bank_sel,
  input  logic            addr_we,
  input  logic [AW-1:0]   addr_wdata,
  output logic [SEGW-1:0] seg_idx,
  output logic            seg_last,
  output logic            word_done,
  output logic [AW-1:0]   addr_q
);
  logic       end_access;
  logic       step_evt;
  step_mode_e mode;

  assign mode       = step_mode_e'(step_mode);
  assign end_access = data_cycle && seg_last && !seg_cfg_we;
  assign step_evt   = instr_exec || (end_access && persist_is_ar);

  seg_counter #(.SEGW(SEGW)) u_seg (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (seg_cfg_we),
    .cfg_start  (seg_cfg_start),
    .cfg_end    (seg_cfg_end),
    .data_cycle (data_cycle),
    .seg_q      (seg_idx),
    .at_end     (seg_last),
    .done_q     (word_done)
  );

  addr_stepper #(.AW(AW), .NBANK(NBANK)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .bank_sel (bank_sel),
    .wr_en    (addr_we),
    .wr_data  (addr_wdata),
    .step_evt (step_evt),
    .mode     (mode),
    .addr_sel (addr_q)
  );

  // R7: a last-slice access aimed elsewhere leaves the address alone
  p_no_step_elsewhere_r7: assert property (@(posedge clk) disable iff (rst)
    (end_access && !persist_is_ar && !instr_exec && !addr_we && $stable(bank_sel))
      |=> $stable(addr_q));
  // R8: an instruction step moves the increment-mode address exactly once
  p_single_step_r8: assert property (@(posedge clk) disable iff (rst)
    (instr_exec && !addr_we && mode == STEP_INC && $stable(bank_sel))
      |=> addr_q == AW'($past(addr_q) + 1'b1));
endmodule

// File: tb/seg_addr_stepper_tb.sv
`timescale 1ns/1ps
module seg_addr_stepper_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       seg_cfg_we = 0;
  logic [1:0] seg_cfg_start = 0, seg_cfg_end = 0;
  logic       data_cycle = 0, persist_is_ar = 0, instr_exec = 0;
  logic [1:0] step_mode = 0;
  logic [0:0] bank_sel = 0;
  logic       addr_we = 0;
  logic [7:0] addr_wdata = 0;
  logic [1:0] seg_idx;
  logic       seg_last, word_done;
  logic [7:0] addr_q;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  seg_addr_stepper u_dut (
    .clk(clk), .rst(rst), .seg_cfg_we(seg_cfg_we), .seg_cfg_start(seg_cfg_start),
    .seg_cfg_end(seg_cfg_end), .data_cycle(data_cycle), .persist_is_ar(persist_is_ar),
    .instr_exec(instr_exec), .step_mode(step_mode), .bank_sel(bank_sel),
    .addr_we(addr_we), .addr_wdata(addr_wdata), .seg_idx(seg_idx),
    .seg_last(seg_last), .word_done(word_done), .addr_q(addr_q)
  );

  typedef struct {
    logic [1:0] seg;
    logic [7:0] addr;
    logic       done;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [1:0] m_start, m_end, m_seg;
  logic [7:0] m_addr [2];

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one clock of stimulus and pushes what must follow it.
  task automatic drive(bit cfg, logic [1:0] st, logic [1:0] en, bit dat, bit par,
                       bit ins, logic [1:0] md, bit sel, bit we, logic [7:0] wd,
                       string tag);
    exp_t e;
    bit atend, evt, done;
    logic [7:0] cur, nx;
    @(negedge clk);
    seg_cfg_we = cfg; seg_cfg_start = st; seg_cfg_end = en; data_cycle = dat;
    persist_is_ar = par; instr_exec = ins; step_mode = md; bank_sel = sel;
    addr_we = we; addr_wdata = wd;
    atend = (m_seg == m_end);
    done  = !cfg && dat && atend;
    evt   = ins || (done && par);
    if (cfg) begin m_start = st; m_end = en; m_seg = st; end
    else if (dat) m_seg = atend ? m_start : m_seg + 2'd1;
    cur = m_addr[sel];
    case (md)
      2'b01: nx = cur + 8'd1;
      2'b10: nx = cur - 8'd1;
      default: nx = cur;
    endcase
    if (we) m_addr[sel] = wd;
    else if (evt) m_addr[sel] = nx;
    e.seg = m_seg; e.addr = m_addr[sel]; e.done = done; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares after each rising edge, once outputs have settled.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "seg_idx", seg_idx, e.seg);
      check(e.tag, "addr_q", addr_q, e.addr);
      check(e.tag, "word_done", word_done, e.done);
    end
  end

  task automatic dcyc(int n, bit par, logic [1:0] md, bit sel, string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 1, par, 0, md, sel, 0, 0, tag);
  endtask

  task automatic idle(int n, logic [1:0] md, bit sel, string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, md, sel, 0, 0, tag);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_start = 0; m_end = 3; m_seg = 0; m_addr[0] = 0; m_addr[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", "seg_idx", seg_idx, 0);
    check("R1", "word_done", word_done, 0);
    check("R1", "addr_q fg", addr_q, 0);
    check("R1", "seg_last", seg_last, 0);
    bank_sel = 1; #0.1;
    check("R1", "addr_q bg", addr_q, 0);
    bank_sel = 0;
    // R3 R4 full word 0..3, increment on the last slice
    dcyc(4, 1, 2'b01, 0, "R3");
    dcyc(4, 1, 2'b01, 0, "R4");
    // R5 holding
    idle(3, 2'b01, 0, "R5");
    // R2 config write with a coinciding data cycle
    drive(1, 2'd1, 2'd2, 1, 1, 0, 2'b01, 0, 0, 0, "R2");
    dcyc(4, 1, 2'b01, 0, "R2");
    // R3 wrap 3 -> 0 with first slice above last
    drive(1, 2'd3, 2'd1, 0, 0, 0, 2'b01, 0, 0, 0, "R2");
    dcyc(6, 1, 2'b01, 0, "R3");
    // R4 equal first and last slices
    drive(1, 2'd2, 2'd2, 0, 0, 0, 2'b01, 0, 0, 0, "R2");
    dcyc(3, 1, 2'b01, 0, "R4");
    // R10 load, then R6 decrement wrap below zero
    drive(0, 0, 0, 0, 0, 0, 2'b10, 0, 1, 8'd0, "R10");
    dcyc(2, 1, 2'b10, 0, "R6");
    // R6 increment wrap above 255
    drive(0, 0, 0, 0, 0, 0, 2'b01, 0, 1, 8'd255, "R10");
    dcyc(2, 1, 2'b01, 0, "R6");
    // R6 encodings 00 and 11 hold
    dcyc(2, 1, 2'b00, 0, "R6");
    dcyc(2, 1, 2'b11, 0, "R6");
    // R7 persistent target elsewhere
    dcyc(3, 0, 2'b01, 0, "R7");
    // R8 instruction step alone and coinciding with a last-slice step
    drive(0, 0, 0, 0, 0, 1, 2'b01, 0, 0, 0, "R8");
    drive(0, 0, 0, 1, 1, 1, 2'b01, 0, 0, 0, "R8");
    drive(0, 0, 0, 0, 0, 1, 2'b10, 0, 0, 0, "R8");
    // R9 background copy
    drive(0, 0, 0, 0, 0, 0, 2'b01, 1, 1, 8'h80, "R9");
    dcyc(2, 1, 2'b01, 1, "R9");
    drive(0, 0, 0, 0, 0, 1, 2'b10, 1, 0, 0, "R9");
    idle(2, 2'b01, 0, "R9");
    dcyc(1, 1, 2'b01, 0, "R9");
    idle(1, 2'b01, 1, "R9");
    // R10 load wins over a coinciding step
    drive(0, 0, 0, 1, 1, 1, 2'b01, 0, 1, 8'h3c, "R10");
    drive(0, 0, 0, 1, 1, 1, 2'b10, 1, 1, 8'h11, "R10");
    idle(2, 2'b01, 0, "R10");
    idle(1, 2'b01, 1, "R10");
    idle(2, 2'b00, 0, "R5");
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule